// File: doc/BRIEF.md
# Identification Page Checksum Verifier

This block sits beside the write path of a 256-byte transceiver identification page. It sees every byte write as an address, a data byte and a valid strobe. It keeps one running modulo-256 sum for each of two protected regions. A lower region spans offsets 0 to 62, and its check byte is stored at offset 63. An upper region spans offsets 64 to 94, and its check byte is stored at offset 95. Once a region and its check byte have all been written, the block compares the sum with the stored check byte and raises a pass or a fail flag for that region. A combined flag shows that the whole page is valid. Offsets 96 to 255 are never examined.

Bytes may arrive in any order, and an offset may be written more than once. Each region keeps a shadow copy of its bytes, so a rewrite takes the old value out of the sum and puts the new value in. A host that needs fresh check bytes can pulse a recompute request. One cycle later the block presents both computed sums for the host to write back. A synchronous clear forgets everything seen so far.

Top module: `idpc_csum_chk`

## Requirements
- R1: When all of offsets 0..62 and offset 63 have been written, base_ok is 1 if the low 8 bits of the sum of the latest values at 0..62 equal the latest value at 63. Otherwise base_bad is 1. The two are never 1 together.
- R2: The same rule holds for the upper region, with bytes 64..94, check byte 95 and the outputs ext_ok / ext_bad.
- R3: A region's two flags stay 0 until every offset in its region and its check-byte offset have each been written at least once since reset or clear.
- R4: A rewrite of an offset replaces its earlier value. The sum always reflects only the most recent value at each offset.
- R5: The verdict depends only on the final contents and not on the order in which offsets were written.
- R6: A write presented at clock edge n updates the flags so that they are visible in the cycle that follows edge n.
- R7: Writes to offsets 96..255 change no flag and no computed sum.
- R8: page_ok is 1 exactly when base_ok and ext_ok are both 1.
- R9: A clear sampled at an edge returns all written-marks, sums, check bytes, flags and rcmp_vld to 0. A write in the same cycle as the clear is discarded.
- R10: A request sampled at edge n (without clear) makes rcmp_vld 1 for the cycle after edge n, and 0 otherwise. rcmp_base and rcmp_ext then carry the low 8 bits of the sums of the latest values written before edge n over 0..62 and 64..94, and unwritten offsets count as 0.
- R11: After reset, all flags and rcmp_vld are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of all tracking state |
| wr_vld | input | 1 | Byte write strobe |
| wr_addr | input | AW (8) | Page offset of the write |
| wr_data | input | DW (8) | Byte written |
| rcmp_req | input | 1 | Recompute request |
| base_ok | output | 1 | Lower region complete and matching |
| base_bad | output | 1 | Lower region complete and mismatching |
| ext_ok | output | 1 | Upper region complete and matching |
| ext_bad | output | 1 | Upper region complete and mismatching |
| page_ok | output | 1 | Both regions pass |
| rcmp_vld | output | 1 | Recomputed values present this cycle |
| rcmp_base | output | DW (8) | Computed check byte for the lower region |
| rcmp_ext | output | DW (8) | Computed check byte for the upper region |

## Verification
The hardest state to reach is a pass verdict that comes out of a long history of rewrites. Random writes scatter over the page, and only a sum that has correctly removed every displaced value can match at the end. The stimulus therefore runs long random write sequences that hit covered offsets, check offsets and ignored offsets alike. It then fills any holes and writes the check bytes the bench model computes, and it expects both regions to pass. Directed cases cover the completing write landing on the check byte versus landing on a data byte, and a clear that collides with a write.

// File: rtl/idpc_pkg.sv
package idpc_pkg;
  localparam int unsigned BASE_LO = 0;
  localparam int unsigned BASE_HI = 62;
  localparam int unsigned BASE_CK = 63;
  localparam int unsigned EXT_LO  = 64;
  localparam int unsigned EXT_HI  = 94;
  localparam int unsigned EXT_CK  = 95;
  localparam int unsigned NRNG    = 2;

  function automatic int unsigned rng_lo(int unsigned g);
    return (g == 0) ? BASE_LO : EXT_LO;
  endfunction

  function automatic int unsigned rng_hi(int unsigned g);
    return (g == 0) ? BASE_HI : EXT_HI;
  endfunction

  function automatic int unsigned rng_ck(int unsigned g);
    return (g == 0) ? BASE_CK : EXT_CK;
  endfunction
endpackage

// File: rtl/idpc_rst_sync.sv
module idpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/idpc_range.sv
module idpc_range #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 62,
  parameter int unsigned CK = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] sum_o,
  output logic          ok_o,
  output logic          bad_o
);
  localparam int unsigned N  = HI - LO + 1;
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [AW:0]   LO_X = LO[AW:0];
  localparam logic [AW:0]   N_X  = N[AW:0];
  localparam logic [AW-1:0] CK_X = CK[AW-1:0];

  logic [AW:0]   off;
  logic [IW-1:0] idx;
  logic          hit_cov, hit_ck, en;
  logic [DW-1:0] old_val;

  logic [DW-1:0] shd [N];
  logic [N-1:0]  mask_q, mask_d;
  logic [DW-1:0] sum_q, sum_d;
  logic [DW-1:0] ck_q, ck_d;
  logic          cks_q, cks_d;

  // offset relative to region start; underflow wraps above N
  assign off     = {1'b0, wr_addr} - LO_X;
  assign idx     = off[IW-1:0];
  assign hit_cov = wr_vld && (off < N_X);
  assign hit_ck  = wr_vld && (wr_addr == CK_X);
  assign old_val = mask_q[idx] ? shd[idx] : '0;
  assign en      = clr | hit_cov | hit_ck;

  always_comb begin
    sum_d  = sum_q;
    mask_d = mask_q;
    ck_d   = ck_q;
    cks_d  = cks_q;
    if (clr) begin
      sum_d  = '0;
      mask_d = '0;
      ck_d   = '0;
      cks_d  = 1'b0;
    end else begin
      if (hit_cov) begin
        sum_d       = sum_q - old_val + wr_data;
        mask_d[idx] = 1'b1;
      end
      if (hit_ck) begin
        ck_d  = wr_data;
        cks_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      mask_q <= '0;
      ck_q   <= '0;
      cks_q  <= 1'b0;
    end else if (en) begin
      sum_q  <= sum_d;
      mask_q <= mask_d;
      ck_q   <= ck_d;
      cks_q  <= cks_d;
    end
  end

  // shadow bytes carry no reset; the written-mask gates their use
  always_ff @(posedge clk) begin
    if (hit_cov && !clr) shd[idx] <= wr_data;
  end

  logic full;
  assign full  = (&mask_q) & cks_q;
  assign sum_o = sum_q;
  assign ok_o  = full & (sum_q == ck_q);
  assign bad_o = full & (sum_q != ck_q);
endmodule

// File: rtl/idpc_rcmp.sv
module idpc_rcmp #(
  parameter int unsigned DW = 8,
  parameter int unsigned NR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             req,
  input  logic [NR*DW-1:0] sums,
  output logic             vld,
  output logic [NR*DW-1:0] vals
);
  logic             vld_q, vld_d, take;
  logic [NR*DW-1:0] val_q, val_d;

  assign take = req & ~clr;

  always_comb begin
    vld_d = take;
    val_d = take ? sums : val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      val_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (take) val_q <= val_d;
    end
  end

  assign vld  = vld_q;
  assign vals = val_q;
endmodule

// File: rtl/idpc_csum_chk.sv
module idpc_csum_chk
  import idpc_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rcmp_req,
  output logic          base_ok,
  output logic          base_bad,
  output logic          ext_ok,
  output logic          ext_bad,
  output logic          page_ok,
  output logic          rcmp_vld,
  output logic [DW-1:0] rcmp_base,
  output logic [DW-1:0] rcmp_ext
);
  localparam int unsigned NR = NRNG;

  logic             rst_s_n;
  logic [NR*DW-1:0] sum_v, rv;
  logic [NR-1:0]    ok_v, bad_v;

  idpc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  for (genvar g = 0; g < NR; g++) begin : g_rng
    idpc_range #(
      .AW (AW),
      .DW (DW),
      .LO (rng_lo(g)),
      .HI (rng_hi(g)),
      .CK (rng_ck(g))
    ) u_rng (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .clr     (clr),
      .wr_vld  (wr_vld),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sum_o   (sum_v[g*DW +: DW]),
      .ok_o    (ok_v[g]),
      .bad_o   (bad_v[g])
    );
  end

  idpc_rcmp #(.DW(DW), .NR(NR)) u_rcmp (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (clr),
    .req   (rcmp_req),
    .sums  (sum_v),
    .vld   (rcmp_vld),
    .vals  (rv)
  );

  assign base_ok   = ok_v[0];
  assign base_bad  = bad_v[0];
  assign ext_ok    = ok_v[1];
  assign ext_bad   = bad_v[1];
  assign page_ok   = &ok_v;
  assign rcmp_base = rv[DW-1:0];
  assign rcmp_ext  = rv[2*DW-1:DW];
endmodule

module idpc_csum_sva #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          wr_vld,
  input logic [AW-1:0] wr_addr,
  input logic          rcmp_req,
  input logic          base_ok,
  input logic          base_bad,
  input logic          ext_ok,
  input logic          ext_bad,
  input logic          page_ok,
  input logic          rcmp_vld
);
  a_r1_base_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_ok && base_bad));

  a_r2_ext_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_ok && ext_bad));

  a_r8_page_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    page_ok |-> (!base_bad && !ext_bad));

  a_r9_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !(base_ok || base_bad || ext_ok || ext_bad || rcmp_vld));

  a_r10_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !rcmp_req |=> !rcmp_vld);

  a_r7_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && (wr_addr >= AW'(96)) && !clr)
      |=> $stable({base_ok, base_bad, ext_ok, ext_bad}));
endmodule

bind idpc_csum_chk idpc_csum_sva #(.AW(AW)) u_sva (.*);

// File: tb/sim_idpc_csum_chk.sv
`timescale 1ns/1ps
module sim_idpc_csum_chk;
  logic       clk = 1'b0;
  logic       rst_n, clr, wr_vld, rcmp_req;
  logic [7:0] wr_addr, wr_data;
  logic       base_ok, base_bad, ext_ok, ext_bad, page_ok, rcmp_vld;
  logic [7:0] rcmp_base, rcmp_ext;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] mem [256];
  bit         wm  [256];

  always #2.5 clk = ~clk;

  idpc_csum_chk u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_vld(wr_vld),
    .wr_addr(wr_addr), .wr_data(wr_data), .rcmp_req(rcmp_req),
    .base_ok(base_ok), .base_bad(base_bad), .ext_ok(ext_ok),
    .ext_bad(ext_bad), .page_ok(page_ok), .rcmp_vld(rcmp_vld),
    .rcmp_base(rcmp_base), .rcmp_ext(rcmp_ext)
  );

  function automatic logic [7:0] msum(int lo, int hi);
    logic [7:0] s = 8'h00;
    for (int i = lo; i <= hi; i++) if (wm[i]) s += mem[i];
    return s;
  endfunction

  function automatic bit mfull(int lo, int hi, int ck);
    bit f = wm[ck];
    for (int i = lo; i <= hi; i++) if (!wm[i]) f = 0;
    return f;
  endfunction

  function automatic bit e_ok(int g);
    if (g == 0) return mfull(0, 62, 63) && (msum(0, 62) == mem[63]);
    return mfull(64, 94, 95) && (msum(64, 94) == mem[95]);
  endfunction

  function automatic bit e_bad(int g);
    if (g == 0) return mfull(0, 62, 63) && (msum(0, 62) != mem[63]);
    return mfull(64, 94, 95) && (msum(64, 94) != mem[95]);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " base_ok"},  {7'd0, base_ok},  {7'd0, e_ok(0)});
    chk({tag, " base_bad"}, {7'd0, base_bad}, {7'd0, e_bad(0)});
    chk({tag, " ext_ok"},   {7'd0, ext_ok},   {7'd0, e_ok(1)});
    chk({tag, " ext_bad"},  {7'd0, ext_bad},  {7'd0, e_bad(1)});
    chk({tag, " page_ok R8"}, {7'd0, page_ok}, {7'd0, e_ok(0) & e_ok(1)});
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_vld = 1'b1; wr_addr = a[7:0]; wr_data = d;
    @(negedge clk);
    wr_vld = 1'b0;
    mem[a] = d; wm[a] = 1;
  endtask

  task automatic do_rcmp(string tag);
    logic [7:0] eb, ee;
    eb = msum(0, 62); ee = msum(64, 94);
    @(negedge clk);
    rcmp_req = 1'b1;
    @(negedge clk);
    rcmp_req = 1'b0;
    chk({tag, " R10 vld"},  {7'd0, rcmp_vld}, 8'd1);
    chk({tag, " R10 base"}, rcmp_base, eb);
    chk({tag, " R10 ext"},  rcmp_ext, ee);
    @(negedge clk);
    chk({tag, " R10 vld drop"}, {7'd0, rcmp_vld}, 8'd0);
  endtask

  task automatic shuffle(ref int p[], input int n);
    for (int i = 0; i < n; i++) p[i] = i;
    for (int i = n - 1; i > 0; i--) begin
      int j, t;
      j = int'($urandom % (i + 1));
      t = p[i]; p[i] = p[j]; p[j] = t;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int p[];
    logic [7:0] v [63];
    logic [7:0] s;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; wm[i] = 0; end
    rst_n = 1'b0; clr = 1'b0; wr_vld = 1'b0; rcmp_req = 1'b0;
    wr_addr = 8'h00; wr_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R11 reset");
    chk("R11 rcmp_vld", {7'd0, rcmp_vld}, 8'd0);

    // R3/R5/R6: base check byte first, data bytes in shuffled order
    p = new[63];
    s = 8'h00;
    for (int i = 0; i < 63; i++) begin v[i] = 8'($urandom); s += v[i]; end
    wr(63, s);
    chk_all("R3 base check only");
    shuffle(p, 63);
    for (int k = 0; k < 63; k++) begin
      wr(p[k], v[p[k]]);
      if (k < 62) chk("R3 base incomplete", {7'd0, base_ok | base_bad}, 8'd0);
    end
    chk("R6 R1 R5 base_ok after last byte", {7'd0, base_ok}, 8'd1);
    chk_all("R1 base done");

    // R2/R6: upper region bytes then wrong check byte, then correct one
    p = new[31];
    shuffle(p, 31);
    for (int k = 0; k < 31; k++) begin
      wr(64 + p[k], 8'($urandom));
      chk("R3 ext incomplete", {7'd0, ext_ok | ext_bad}, 8'd0);
    end
    wr(95, msum(64, 94) + 8'd1);
    chk("R2 R6 ext_bad on wrong check", {7'd0, ext_bad}, 8'd1);
    chk_all("R2 ext wrong");
    wr(95, msum(64, 94));
    chk("R2 ext_ok", {7'd0, ext_ok}, 8'd1);
    chk("R8 page_ok", {7'd0, page_ok}, 8'd1);

    // R4: rewrite a covered byte, then restore it
    s = mem[17];
    wr(17, s ^ 8'h5A);
    chk("R4 rewrite makes base_bad", {7'd0, base_bad}, 8'd1);
    chk("R8 page drops", {7'd0, page_ok}, 8'd0);
    wr(17, s);
    chk("R4 restore base_ok", {7'd0, base_ok}, 8'd1);
    wr(70, mem[70] + 8'd3);
    chk_all("R4 ext rewrite");

    // R7: high offsets ignored
    wr(70, mem[70] - 8'd3);
    for (int k = 0; k < 24; k++) begin
      int a;
      a = 96 + int'($urandom % 160);
      @(negedge clk);
      wr_vld = 1'b1; wr_addr = a[7:0]; wr_data = 8'($urandom);
      @(negedge clk);
      wr_vld = 1'b0;
      chk_all("R7 high write");
    end
    do_rcmp("R7 sums intact");

    // R9: clear colliding with a write
    @(negedge clk);
    clr = 1'b1; wr_vld = 1'b1; wr_addr = 8'd5; wr_data = 8'hA5;
    @(negedge clk);
    clr = 1'b0; wr_vld = 1'b0;
    for (int i = 0; i < 256; i++) wm[i] = 0;
    chk_all("R9 after clear");
    do_rcmp("R9 write discarded");

    // R10: partial contents, unwritten counted as zero
    wr(3, 8'h11); wr(40, 8'hF2); wr(80, 8'h7C); wr(80, 8'h05);
    do_rcmp("R10 partial");

    // R5: random write storms, then complete and seal both regions
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 250; k++) begin
        wr(int'($urandom % 128), 8'($urandom));
        chk_all("R5 random");
      end
      for (int i = 0; i < 95; i++)
        if (!wm[i] && i != 63) wr(i, 8'($urandom));
      chk_all("R5 filled");
      wr(63, msum(0, 62));
      wr(95, msum(64, 94));
      chk("R5 R1 sealed base", {7'd0, base_ok}, 8'd1);
      chk("R5 R2 sealed ext", {7'd0, ext_ok}, 8'd1);
      chk("R5 R8 sealed page", {7'd0, page_ok}, 8'd1);
      do_rcmp("R5 rcmp");
    end

    finish_run();
  end
endmodule